// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every internal reset cause of a small 8-bit controller and turns it into one ordered reset release. The causes are a power-on event, an illegal opcode (including a STOP instruction while stopping is disabled by configuration), an opcode fetch from an unmapped address, a low-supply trip, a watchdog expiry and a USB bus reset. Each cause sets its own sticky bit in a read-clear status register. For every cause, the block enables the pull-down of the external reset pin.

A single 12-bit counter times everything. After a cause, the pin is held low for one full counter wrap (4096 reference cycles) and then for a further 32 cycles. The pin is then released, and the CPU stays in reset for another 32 cycles before its reset-vector fetch. While the core runs, the same counter runs freely, and each wrap gives a one-cycle tick that clocks the watchdog. A permitted STOP gates the bus clocks. A later wake event starts a recovery wait of either 32 or 4096 cycles, selected by a configuration bit, before the clocks return.

Top module: `rst_seq_top`

## Requirements
- R1: A pulse on `bad_opcode`, or `stop_exec` while `stop_en` is 0, starts a reset sequence and sets status bit 1. In that case the bus clocks are not gated.
- R2: `bad_addr` starts a reset sequence and sets status bit 2 only when `op_fetch` is high in the same cycle. With `op_fetch` low, the pin stays released and the status is unchanged.
- R3: Every cause sampled at a clock edge drives `ext_rst_low` high right after that edge and sets its status bit right after that edge. The status bits are: bit 0 power-on, bit 1 illegal opcode, bit 2 illegal address, bit 3 low supply, bit 4 watchdog, bit 5 USB reset.
- R4: `ext_rst_low` stays high for exactly 4096 + 32 = 4128 cycles after the sampling edge.
- R5: `cpu_rst` is high whenever the pin is driven, and falls exactly 32 cycles after the pin is released (4160 cycles after the sampling edge).
- R6: Once the core runs, `wdog_tick` pulses for one cycle 4095 cycles after run entry and every 4096 cycles after that. It is never high while `cpu_rst` is high.
- R7: A `stop_exec` with `stop_en` at 1 clears `bus_clk_en` right after the edge. After a `wake` pulse, `bus_clk_en` returns 32 cycles later if `short_rec` is 1, and 4096 cycles later if it is 0.
- R8: Status bits stay set until a `stat_rd` pulse. The status reads zero after the edge that samples the pulse, except for causes sampled at that same edge, which stay set.
- R9: `por_n` low asynchronously sets the status to only bit 0 and enters the pin-hold phase. After release, timing follows R4 and R5 counted from the last edge before the first counting edge.
- R10: A cause that arrives during an ongoing sequence restarts the full timing from its own sampling edge. Its bit is ORed into the status.
- R11: `wake` has no effect while the core is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| stop_en | input | 1 | Configuration: STOP permitted |
| short_rec | input | 1 | Configuration: short stop recovery |
| stop_exec | input | 1 | STOP instruction executed (strobe) |
| bad_opcode | input | 1 | Illegal opcode decoded (strobe) |
| bad_addr | input | 1 | Access to an unmapped address (strobe) |
| op_fetch | input | 1 | Current access is an opcode fetch |
| lvi_trip | input | 1 | Low-supply detector trip |
| wdog_expire | input | 1 | Watchdog timeout |
| usb_bus_rst | input | 1 | USB bus reset detected |
| wake | input | 1 | Interrupt or break wake from stop |
| stat_rd | input | 1 | Status register read strobe |
| ext_rst_low | output | 1 | Pull-down enable for the external reset pin |
| cpu_rst | output | 1 | Reset to the CPU core, active high |
| bus_clk_en | output | 1 | Bus clock enable |
| wdog_tick | output | 1 | Watchdog prescaler tick |
| cause_stat | output | 6 | Sticky reset-cause status |

## Verification
Every output decodes registered state, so each result appears after a fixed number of edges counted from the edge that samples the stimulus. For a cause sampled at edge C, the pin is due at C, pin release at C+4128, CPU release at C+4160 and the first watchdog tick at C+8255. Stop recovery is due 32 or 4096 edges after the wake edge. The driver notes the number of the sampling edge and queues each expected value with its exact due cycle, including the cycle just before each transition. The monitor compares the outputs on falling edges at exactly those cycles, and it also reports any item it did not reach by its due cycle.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  localparam int NCAUSE = 6;
  localparam int C_POR  = 0;
  localparam int C_ILOP = 1;
  localparam int C_ILAD = 2;
  localparam int C_LVI  = 3;
  localparam int C_WDOG = 4;
  localparam int C_USB  = 5;

  typedef enum logic [2:0] {
    S_HOLD_LONG  = 3'd0,
    S_HOLD_SHORT = 3'd1,
    S_TAIL       = 3'd2,
    S_RUN        = 3'd3,
    S_STOP       = 3'd4,
    S_RECOV      = 3'd5
  } seq_state_t;

  // Collect the synchronous cause strobes into status-bit positions.
  function automatic logic [NCAUSE-1:0] gather_causes(
    input logic stop_exec, input logic stop_en, input logic bad_opcode,
    input logic bad_addr, input logic op_fetch, input logic lvi,
    input logic wdog, input logic usb);
    logic [NCAUSE-1:0] c;
    c         = '0;
    c[C_ILOP] = bad_opcode | (stop_exec & ~stop_en);
    c[C_ILAD] = bad_addr & op_fetch;
    c[C_LVI]  = lvi;
    c[C_WDOG] = wdog;
    c[C_USB]  = usb;
    return c;
  endfunction

  // Next status value: optional clear on read, then OR in new causes.
  function automatic logic [NCAUSE-1:0] next_status(
    input logic [NCAUSE-1:0] cur, input logic rd, input logic [NCAUSE-1:0] fresh);
    return (rd ? '0 : cur) | fresh;
  endfunction

  // Total cycles from sampling edge to pin release and to CPU release.
  function automatic int pin_hold_cycles(input int cnt_w, input int short_len);
    return (1 << cnt_w) + short_len;
  endfunction

  function automatic int cpu_hold_cycles(input int cnt_w, input int short_len);
    return (1 << cnt_w) + 2 * short_len;
  endfunction

endpackage

// File: rtl/rst_seq_counter.sv
module rst_seq_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign at_top = (cnt == TOP);

  // R4: a clear request always restarts the count from zero
  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R6: without a clear the count advances by exactly one, wrapping at the top
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rst_cause_latch.sv
module rst_cause_latch
  import rst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic [NCAUSE-1:0] fresh,
  input  logic              rd,
  output logic [NCAUSE-1:0] stat
);

  localparam logic [NCAUSE-1:0] POR_VAL = NCAUSE'(1) << C_POR;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stat <= POR_VAL;
    else        stat <= next_status(stat, rd, fresh);
  end

  // R8: causes sampled at an edge are visible as set after it
  p_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    (|fresh) |=> ((stat & $past(fresh)) == $past(fresh)));

  // R8: without a read, no bit is ever lost
  p_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
    !rd |=> ((stat & $past(stat)) == $past(stat)));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SHORT_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cause_any,
  input  logic             stop_go,
  input  logic             wake,
  input  logic             short_rec,
  input  logic [CNT_W-1:0] cnt,
  output seq_state_t       st,
  output logic             clr
);

  localparam logic [CNT_W-1:0] LAST_LONG  = '1;
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);

  seq_state_t       nxt;
  logic [CNT_W-1:0] rec_last;

  assign rec_last = short_rec ? LAST_SHORT : LAST_LONG;

  always_comb begin
    nxt = st;
    if (cause_any) begin
      nxt = S_HOLD_LONG;
    end else begin
      case (st)
        S_HOLD_LONG:  if (cnt == LAST_LONG)  nxt = S_HOLD_SHORT;
        S_HOLD_SHORT: if (cnt == LAST_SHORT) nxt = S_TAIL;
        S_TAIL:       if (cnt == LAST_SHORT) nxt = S_RUN;
        S_RUN:        if (stop_go)           nxt = S_STOP;
        S_STOP:       if (wake)              nxt = S_RECOV;
        S_RECOV:      if (cnt == rec_last)   nxt = S_RUN;
        default:                             nxt = S_HOLD_LONG;
      endcase
    end
  end

  assign clr = cause_any || (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_HOLD_LONG;
    else        st <= nxt;
  end

  // R10: any cause restarts the sequence at the first hold phase
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cause_any |=> (st == S_HOLD_LONG));

  // R7: a permitted stop in run enters the stopped state
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && stop_go && !cause_any) |=> (st == S_STOP));

  // R11: wake leaves a running core running
  p_wake_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && wake && !stop_go && !cause_any) |=> (st == S_RUN));

  // R5: run is only reached from the tail or from stop recovery
  p_run_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_RUN) |-> ($past(st) == S_TAIL || $past(st) == S_RECOV));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int SHORT_LEN = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              stop_en,
  input  logic              short_rec,
  input  logic              stop_exec,
  input  logic              bad_opcode,
  input  logic              bad_addr,
  input  logic              op_fetch,
  input  logic              lvi_trip,
  input  logic              wdog_expire,
  input  logic              usb_bus_rst,
  input  logic              wake,
  input  logic              stat_rd,
  output logic              ext_rst_low,
  output logic              cpu_rst,
  output logic              bus_clk_en,
  output logic              wdog_tick,
  output logic [NCAUSE-1:0] cause_stat
);

  logic [NCAUSE-1:0] fresh;
  logic              cause_any;
  logic              stop_go;
  logic              cnt_clr;
  logic              cnt_top;
  logic [CNT_W-1:0]  cnt;
  seq_state_t        st;

  assign fresh     = gather_causes(stop_exec, stop_en, bad_opcode, bad_addr,
                                   op_fetch, lvi_trip, wdog_expire, usb_bus_rst);
  assign cause_any = |fresh;
  assign stop_go   = stop_exec & stop_en;

  rst_cause_latch u_latch (
    .clk   (clk),
    .por_n (por_n),
    .fresh (fresh),
    .rd    (stat_rd),
    .stat  (cause_stat)
  );

  rst_seq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (por_n),
    .clr    (cnt_clr),
    .cnt    (cnt),
    .at_top (cnt_top)
  );

  rst_seq_fsm #(.CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN)) u_fsm (
    .clk       (clk),
    .rst_n     (por_n),
    .cause_any (cause_any),
    .stop_go   (stop_go),
    .wake      (wake),
    .short_rec (short_rec),
    .cnt       (cnt),
    .st        (st),
    .clr       (cnt_clr)
  );

  assign ext_rst_low = (st == S_HOLD_LONG) || (st == S_HOLD_SHORT);
  assign cpu_rst     = ext_rst_low || (st == S_TAIL);
  assign bus_clk_en  = !((st == S_STOP) || (st == S_RECOV));
  assign wdog_tick   = (st == S_RUN) && cnt_top;

  // R5: the core is held whenever the pin is pulled low
  p_pin_cpu_r5: assert property (@(posedge clk) disable iff (!por_n)
    ext_rst_low |-> cpu_rst);

  // R6: the watchdog tick only occurs with the core running and clocked
  p_tick_run_r6: assert property (@(posedge clk) disable iff (!por_n)
    wdog_tick |-> (!cpu_rst && bus_clk_en));

  // R2: a data access to an unmapped address does not pull the pin
  p_data_ignore_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_rst && bad_addr && !op_fetch && !cause_any) |=> !ext_rst_low);

  // R3: every cause pulls the pin right after its sampling edge
  p_pin_cause_r3: assert property (@(posedge clk) disable iff (!por_n)
    cause_any |=> ext_rst_low);

endmodule

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;

  localparam int PIN_HOLD = 4128;
  localparam int CPU_HOLD = 4160;

  typedef struct {
    int          due;
    int          kind;
    logic [5:0]  val;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic stop_en = 1'b1, short_rec = 1'b1;
  logic stop_exec = 0, bad_opcode = 0, bad_addr = 0, op_fetch = 0;
  logic lvi_trip = 0, wdog_expire = 0, usb_bus_rst = 0, wake = 0, stat_rd = 0;
  logic ext_rst_low, cpu_rst, bus_clk_en, wdog_tick;
  logic [5:0] cause_stat;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  exp_t sb[$];
  exp_t it;
  logic [5:0] act;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_seq_top dut (
    .clk(clk), .por_n(por_n), .stop_en(stop_en), .short_rec(short_rec),
    .stop_exec(stop_exec), .bad_opcode(bad_opcode), .bad_addr(bad_addr),
    .op_fetch(op_fetch), .lvi_trip(lvi_trip), .wdog_expire(wdog_expire),
    .usb_bus_rst(usb_bus_rst), .wake(wake), .stat_rd(stat_rd),
    .ext_rst_low(ext_rst_low), .cpu_rst(cpu_rst), .bus_clk_en(bus_clk_en),
    .wdog_tick(wdog_tick), .cause_stat(cause_stat)
  );

  function automatic logic [5:0] sample(input int kind);
    case (kind)
      0:       return {5'd0, ext_rst_low};
      1:       return {5'd0, cpu_rst};
      2:       return {5'd0, bus_clk_en};
      3:       return {5'd0, wdog_tick};
      default: return cause_stat;
    endcase
  endfunction

  // Monitor: pop and compare items whose due cycle has come.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it  = sb.pop_front();
      act = sample(it.kind);
      nchk++;
      if (it.due < cyc || act !== it.val) begin
        nfail++;
        $display("FAIL %s kind=%0d due=%0d at=%0d actual=%b expected=%b",
                 it.tag, it.kind, it.due, cyc, act, it.val);
      end
    end
  end

  task automatic expect_at(input int due, input int kind, input logic [5:0] v,
                           input string tag);
    exp_t e;
    e.due = due; e.kind = kind; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // Bits: 0 stop_exec,1 bad_addr,2 op_fetch,3 lvi,4 wdog,5 usb,6 wake,7 rd,8 bad_opcode
  task automatic drive(input logic [8:0] m, output int c);
    @(negedge clk);
    stop_exec = m[0]; bad_addr = m[1]; op_fetch = m[2]; lvi_trip = m[3];
    wdog_expire = m[4]; usb_bus_rst = m[5]; wake = m[6]; stat_rd = m[7];
    bad_opcode = m[8];
    @(posedge clk); #1;
    c = cyc;
    stop_exec = 0; bad_addr = 0; op_fetch = 0; lvi_trip = 0; wdog_expire = 0;
    usb_bus_rst = 0; wake = 0; stat_rd = 0; bad_opcode = 0;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Full reset-sequence expectations relative to the sampling edge c0.
  task automatic push_seq(input int c0, input logic [5:0] st, input bit tick);
    expect_at(c0, 0, 6'd1, "R3");
    expect_at(c0, 1, 6'd1, "R5");
    expect_at(c0, 4, st, "R3");
    expect_at(c0 + 4095, 3, 6'd0, "R6");
    expect_at(c0 + PIN_HOLD - 1, 0, 6'd1, "R4");
    expect_at(c0 + PIN_HOLD, 0, 6'd0, "R4");
    expect_at(c0 + PIN_HOLD, 1, 6'd1, "R5");
    expect_at(c0 + CPU_HOLD - 1, 1, 6'd1, "R5");
    expect_at(c0 + CPU_HOLD, 1, 6'd0, "R5");
    if (tick) begin
      expect_at(c0 + CPU_HOLD + 4094, 3, 6'd0, "R6");
      expect_at(c0 + CPU_HOLD + 4095, 3, 6'd1, "R6");
      expect_at(c0 + CPU_HOLD + 4096, 3, 6'd0, "R6");
      expect_at(c0 + CPU_HOLD + 8191, 3, 6'd1, "R6");
    end
  endtask

  task automatic read_clear(input string tag);
    int c;
    drive(9'h080, c);
    expect_at(c, 4, 6'd0, tag);
    drain();
  endtask

  task automatic por_cycle();
    int c0;
    @(negedge clk);
    por_n = 1'b0;
    expect_at(cyc + 1, 4, 6'b000001, "R9");
    expect_at(cyc + 1, 0, 6'd1, "R9");
    drain();
    @(posedge clk); #1;
    por_n = 1'b1;
    c0 = cyc;
    push_seq(c0, 6'b000001, 1'b1);
    drain();
  endtask

  // Watchdog: a hang counts as a failure and still reports.
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int c, c1, w;
    repeat (3) @(posedge clk);
    // R9: power-on state and sequence, then R6 watchdog tick
    por_cycle();
    expect_at(cyc + 1, 4, 6'b000001, "R8");
    drain();
    read_clear("R8");

    // R2: data access to an unmapped address is ignored
    drive(9'h002, c);
    expect_at(c, 0, 6'd0, "R2");
    expect_at(c, 4, 6'd0, "R2");
    expect_at(c + 1, 1, 6'd0, "R2");
    drain();
    // R2: opcode fetch from an unmapped address resets
    drive(9'h006, c);
    push_seq(c, 6'b000100, 1'b0);
    drain();
    read_clear("R8");

    // R1: STOP while stopping is disabled
    stop_en = 1'b0;
    drive(9'h001, c);
    expect_at(c, 2, 6'd1, "R1");
    push_seq(c, 6'b000010, 1'b0);
    drain();
    stop_en = 1'b1;
    read_clear("R8");

    // R10: low supply, restarted by an illegal opcode
    drive(9'h008, c);
    expect_at(c, 0, 6'd1, "R3");
    expect_at(c, 4, 6'b001000, "R3");
    expect_at(c + 98, 0, 6'd1, "R10");
    drain();
    while (cyc < c + 99) @(negedge clk);
    drive(9'h100, c1);
    push_seq(c1, 6'b001010, 1'b0);
    drain();
    read_clear("R10");

    // R3: watchdog expiry; R8: read with a new USB cause at the same edge
    drive(9'h010, c);
    push_seq(c, 6'b010000, 1'b0);
    drain();
    drive(9'h0A0, c);
    push_seq(c, 6'b100000, 1'b0);
    drain();
    read_clear("R8");

    // R7: short stop recovery
    short_rec = 1'b1;
    drive(9'h001, c);
    expect_at(c, 2, 6'd0, "R7");
    expect_at(c, 0, 6'd0, "R7");
    drain();
    repeat (10) @(negedge clk);
    drive(9'h040, w);
    expect_at(w + 31, 2, 6'd0, "R7");
    expect_at(w + 32, 2, 6'd1, "R7");
    drain();

    // R11: wake while running has no effect
    drive(9'h040, w);
    expect_at(w, 2, 6'd1, "R11");
    expect_at(w, 0, 6'd0, "R11");
    expect_at(w + 40, 2, 6'd1, "R11");
    drain();

    // R7: long stop recovery
    short_rec = 1'b0;
    drive(9'h001, c);
    expect_at(c, 2, 6'd0, "R7");
    drain();
    drive(9'h040, w);
    expect_at(w + 4095, 2, 6'd0, "R7");
    expect_at(w + 4096, 2, 6'd1, "R7");
    drain();

    // R9: power-on clears the other cause bits
    drive(9'h020, c);
    expect_at(c, 4, 6'b100000, "R3");
    drain();
    por_cycle();

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule